// File: doc/BRIEF.md
# SECDED Memory Guard with Error Escalation

This block sits between the system bus and a 16-bit nonvolatile memory array. Each time a word is written, it computes a set of check bits and stores them next to the data. Each time a word is read, it checks the stored word again. It repairs any single flipped bit before the data reaches the bus, and it recognises words that hold two flipped bits. A byte write is done as a read-modify-write of the whole word. The check bits therefore always cover all 16 data bits.

There are two error classes, correctable and uncorrectable. Each class has a sticky flag in a small control register, and that register also holds three enable bits. A correctable error can raise a non-maskable interrupt request. An uncorrectable error always sends a flush pulse to the read cache. It also raises either an interrupt request or a power-up-clear reset request. The reset enable takes priority over the interrupt enable.

Top module: `mem_ecc_unit`

## Requirements
- R1: A word write with both byte enables set stores one memory word of 22 bits. Data bits 15:0 are stored unchanged in memory bits 15:0, and the six check bits are stored in bits 21:16. Reading back an unaltered word returns the written data and raises no flag or request.
- R2: A read that is accepted (`bus_req` high, `bus_we` low, `bus_ready` high) is answered exactly two cycles later: `bus_rvalid` is high for one cycle and `bus_rdata` holds the word.
- R3: A write with only one byte enable set changes only that byte lane and keeps the other lane's current value. `bus_be[0]` selects bits 7:0 and `bus_be[1]` selects bits 15:8. `bus_ready` is low in the cycle after the partial write is accepted, and high again in the cycle after that.
- R4: A read whose stored word has a single flipped bit in memory bits 15:0 returns the corrected data and sets the correctable flag.
- R5: A read whose stored word has a single flipped bit in memory bits 21:16 returns the data unchanged and sets the correctable flag.
- R6: A correctable error raises `nmi_req` for one cycle, in the same cycle as its `bus_rvalid`, when the correctable interrupt enable is set. No request is raised when that enable is clear.
- R7: A read whose stored word has two flipped bits sets the uncorrectable flag and pulses `cache_flush` for one cycle, in the same cycle as its `bus_rvalid`.
- R8: An uncorrectable error pulses `rst_req` when the reset enable is set, and in that case never `nmi_req`, whatever the interrupt enable holds. When the reset enable is clear, the error pulses `nmi_req` only if the uncorrectable interrupt enable is set.
- R9: Both flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An error detected in the same cycle as a clear keeps the flag set.
- R10: The control register is laid out as follows: bit 0 is the correctable flag, bit 1 the uncorrectable flag, bit 4 the correctable interrupt enable, bit 5 the uncorrectable interrupt enable and bit 6 the uncorrectable reset enable. The other bits read 0, and `reg_rdata` shows the current contents.
- R11: After reset all flags, enables and requests are 0, `bus_rvalid` is 0 and `bus_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 16 | Read data, corrected when possible |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | 22 | Check bits and data to store |
| mem_rdata | input | 22 | Stored word, valid one cycle after a read strobe |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | Power-up-clear reset request pulse |
| cache_flush | output | 1 | Read cache flush pulse |

## Verification
The in-line properties assume that the array returns a stored word exactly one cycle after a read strobe. They also assume that the array returns the word last written at that address, apart from bits that the bench itself flips. The bench memory model follows this timing exactly. Errors are injected only while the block is idle, by flipping chosen bits of a stored word between accesses. No read is issued while an earlier one is in flight, so each response pairs with exactly one expected entry. Errors inside a read-modify-write are injected only while every enable is clear. In that case a flag is set but no request pulse appears without an answering read.

// File: rtl/mecc_pkg.sv
package mecc_pkg;

   // Control register layout
   localparam int CSR_W       = 8;
   localparam int CSR_CE_FLAG = 0;
   localparam int CSR_UE_FLAG = 1;
   localparam int CSR_CE_IE   = 4;
   localparam int CSR_UE_IE   = 5;
   localparam int CSR_UE_RST  = 6;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_MERGE = 1'b1
   } seq_e;

   // Number of Hamming check bits needed to cover dw data bits
   function automatic int ham_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // One-based codeword position of data bit idx (skips power-of-two slots)
   function automatic int data_pos(input int idx);
      int pos;
      int cnt;
      pos = 0;
      cnt = 0;
      for (int k = 3; k < 1024; k++) begin
         if (((k & (k - 1)) != 0) && (pos == 0)) begin
            if (cnt == idx) pos = k;
            cnt++;
         end
      end
      return pos;
   endfunction

   // Data bits covered by Hamming check bit b
   function automatic logic [63:0] cover_mask(input int b, input int dw);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) begin
         if (((data_pos(i) >> b) & 1) != 0) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mecc_enc.sv
module mecc_enc
   import mecc_pkg::*;
#(
   parameter  int DW = 16,
   localparam int HW = ham_bits(DW),
   localparam int CW = HW + 1
) (
   input  logic [DW-1:0] data,
   output logic [CW-1:0] chk
);

   logic [HW-1:0] ham;

   if (DW > 57 || DW < 4) begin : g_bad_width
      $error("mecc_enc: DW out of supported range");
   end

   for (genvar b = 0; b < HW; b++) begin : g_ham
      localparam logic [63:0] MASK = cover_mask(b, DW);
      assign ham[b] = ^(data & MASK[DW-1:0]);
   end

   // Top bit: overall parity over data and Hamming bits
   assign chk = {^{data, ham}, ham};

endmodule

// File: rtl/mecc_dec.sv
module mecc_dec
   import mecc_pkg::*;
#(
   parameter  int DW = 16,
   localparam int HW = ham_bits(DW),
   localparam int CW = HW + 1
) (
   input  logic [DW-1:0] data_in,
   input  logic [CW-1:0] chk_in,
   output logic [DW-1:0] data_out,
   output logic          err_ce,
   output logic          err_ue
);

   logic [CW-1:0] re_chk;
   logic [HW-1:0] syn;
   logic [DW-1:0] flip;
   logic          par_err;
   logic          syn_zero;
   logic          syn_chk;
   logic          single_ok;

   mecc_enc #(.DW(DW)) u_reenc (
      .data (data_in),
      .chk  (re_chk)
   );

   assign syn      = re_chk[HW-1:0] ^ chk_in[HW-1:0];
   // Overall parity of the stored word, derived from the recomputed parity
   assign par_err  = re_chk[HW] ^ (^syn) ^ chk_in[HW];
   assign syn_zero = (syn == '0);
   assign syn_chk  = $onehot(syn);

   for (genvar i = 0; i < DW; i++) begin : g_flip
      localparam int POS = data_pos(i);
      assign flip[i] = par_err && (syn == HW'(POS));
   end

   assign single_ok = syn_zero || syn_chk || (|flip);
   assign data_out  = data_in ^ flip;
   assign err_ce    = par_err && single_ok;
   assign err_ue    = (!par_err && !syn_zero) || (par_err && !single_ok);

endmodule

// File: rtl/mecc_status.sv
module mecc_status
   import mecc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_evt,
   input  logic             ue_evt,
   input  logic             reg_we,
   input  logic [CSR_W-1:0] reg_wdata,
   output logic [CSR_W-1:0] reg_rdata,
   output logic             nmi_req,
   output logic             rst_req,
   output logic             cache_flush
);

   logic ce_flag_q, ue_flag_q;
   logic ce_ie_q, ue_ie_q, ue_rst_q;
   logic ce_flag_d, ue_flag_d;
   logic nmi_q, rst_q, flush_q;

   always_comb begin
      ce_flag_d = ce_flag_q;
      ue_flag_d = ue_flag_q;
      if (reg_we && reg_wdata[CSR_CE_FLAG]) ce_flag_d = 1'b0;
      if (reg_we && reg_wdata[CSR_UE_FLAG]) ue_flag_d = 1'b0;
      if (ce_evt) ce_flag_d = 1'b1;
      if (ue_evt) ue_flag_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_flag_q <= 1'b0;
         ue_flag_q <= 1'b0;
         ce_ie_q   <= 1'b0;
         ue_ie_q   <= 1'b0;
         ue_rst_q  <= 1'b0;
         nmi_q     <= 1'b0;
         rst_q     <= 1'b0;
         flush_q   <= 1'b0;
      end else begin
         ce_flag_q <= ce_flag_d;
         ue_flag_q <= ue_flag_d;
         if (reg_we) begin
            ce_ie_q  <= reg_wdata[CSR_CE_IE];
            ue_ie_q  <= reg_wdata[CSR_UE_IE];
            ue_rst_q <= reg_wdata[CSR_UE_RST];
         end
         nmi_q   <= (ce_evt && ce_ie_q) || (ue_evt && ue_ie_q && !ue_rst_q);
         rst_q   <= ue_evt && ue_rst_q;
         flush_q <= ue_evt;
      end
   end

   always_comb begin
      reg_rdata              = '0;
      reg_rdata[CSR_CE_FLAG] = ce_flag_q;
      reg_rdata[CSR_UE_FLAG] = ue_flag_q;
      reg_rdata[CSR_CE_IE]   = ce_ie_q;
      reg_rdata[CSR_UE_IE]   = ue_ie_q;
      reg_rdata[CSR_UE_RST]  = ue_rst_q;
   end

   assign nmi_req     = nmi_q;
   assign rst_req     = rst_q;
   assign cache_flush = flush_q;

   AST_UE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ue_evt |=> cache_flush); // R7
   AST_UE_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ue_evt |=> reg_rdata[CSR_UE_FLAG]); // R7
   AST_RST_BEATS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && reg_rdata[CSR_UE_RST]) |=> (rst_req && !nmi_req)); // R8
   AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[CSR_CE_FLAG] && !(reg_we && reg_wdata[CSR_CE_FLAG])) |=> reg_rdata[CSR_CE_FLAG]); // R9
   AST_NMI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> $past(ce_evt || ue_evt)); // R6

endmodule

// File: rtl/mem_ecc_unit.sv
module mem_ecc_unit
   import mecc_pkg::*;
#(
   parameter  int DATA_W = 16,
   parameter  int ADDR_W = 10,
   parameter  int BYTE_W = 8,
   localparam int LANES  = DATA_W / BYTE_W,
   localparam int CHK_W  = ham_bits(DATA_W) + 1,
   localparam int MEM_W  = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [LANES-1:0]  bus_be,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ready,
   output logic              bus_rvalid,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [MEM_W-1:0]  mem_wdata,
   input  logic [MEM_W-1:0]  mem_rdata,
   input  logic              reg_we,
   input  logic [CSR_W-1:0]  reg_wdata,
   output logic [CSR_W-1:0]  reg_rdata,
   output logic              nmi_req,
   output logic              rst_req,
   output logic              cache_flush
);

   if (DATA_W % BYTE_W != 0) begin : g_bad_lanes
      $error("mem_ecc_unit: DATA_W must be a multiple of BYTE_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mem_ecc_unit: ADDR_W must be positive");
   end

   seq_e              seq_q;
   logic              acc, rd_acc, full_acc, part_acc;
   logic              rd_pend_q;
   logic [ADDR_W-1:0] m_addr_q;
   logic [LANES-1:0]  m_be_q;
   logic [DATA_W-1:0] m_wdata_q;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] enc_in;
   logic [CHK_W-1:0]  enc_chk;
   logic [DATA_W-1:0] dec_data;
   logic              dec_ce, dec_ue, chk_live;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   assign bus_ready = (seq_q == SEQ_IDLE);
   assign acc       = bus_req && bus_ready;
   assign rd_acc    = acc && !bus_we;
   assign full_acc  = acc && bus_we && (&bus_be);
   assign part_acc  = acc && bus_we && !(&bus_be) && (|bus_be);

   // Sequencing: partial writes take a merge cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q     <= SEQ_IDLE;
         rd_pend_q <= 1'b0;
         m_addr_q  <= '0;
         m_be_q    <= '0;
         m_wdata_q <= '0;
      end else begin
         rd_pend_q <= rd_acc;
         if (part_acc) begin
            seq_q     <= SEQ_MERGE;
            m_addr_q  <= bus_addr;
            m_be_q    <= bus_be;
            m_wdata_q <= bus_wdata;
         end else begin
            seq_q <= SEQ_IDLE;
         end
      end
   end

   // Stored word check and correction
   mecc_dec #(.DW(DATA_W)) u_dec (
      .data_in  (mem_rdata[DATA_W-1:0]),
      .chk_in   (mem_rdata[MEM_W-1:DATA_W]),
      .data_out (dec_data),
      .err_ce   (dec_ce),
      .err_ue   (dec_ue)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*BYTE_W +: BYTE_W] = m_be_q[l] ? m_wdata_q[l*BYTE_W +: BYTE_W]
                                                    : dec_data[l*BYTE_W +: BYTE_W];
   end

   assign enc_in = (seq_q == SEQ_MERGE) ? merged : bus_wdata;

   mecc_enc #(.DW(DATA_W)) u_enc (
      .data (enc_in),
      .chk  (enc_chk)
   );

   always_comb begin
      if (seq_q == SEQ_MERGE) begin
         mem_en   = 1'b1;
         mem_we   = 1'b1;
         mem_addr = m_addr_q;
      end else begin
         mem_en   = rd_acc || full_acc || part_acc;
         mem_we   = full_acc;
         mem_addr = bus_addr;
      end
      mem_wdata = {enc_chk, enc_in};
   end

   assign chk_live = rd_pend_q || (seq_q == SEQ_MERGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= rd_pend_q;
         if (rd_pend_q) rdata_q <= dec_data;
      end
   end

   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = rdata_q;

   mecc_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce_evt      (chk_live && dec_ce),
      .ue_evt      (chk_live && dec_ue),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .nmi_req     (nmi_req),
      .rst_req     (rst_req),
      .cache_flush (cache_flush)
   );

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |-> ##2 bus_rvalid); // R2
   AST_MERGE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      part_acc |=> (!bus_ready && mem_we)); // R3
   AST_MERGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |=> bus_ready); // R3

endmodule

// File: tb/sim_mem_ecc_unit.sv
module sim_mem_ecc_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int MW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0, bus_we = 1'b0;
   logic [1:0]    bus_be = 2'b00;
   logic [AW-1:0] bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic          bus_ready, bus_rvalid;
   logic [15:0]   bus_rdata;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [MW-1:0] mem_wdata;
   logic [MW-1:0] mem_rdata = '0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          nmi_req, rst_req, cache_flush;

   logic [MW-1:0] mem [0:(1<<AW)-1];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   typedef struct packed {
      logic [15:0] data;
      logic        chk_data;
      logic        nmi;
      logic        rst;
      logic        flush;
   } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_ecc_unit #(.DATA_W(16), .ADDR_W(AW), .BYTE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
      .bus_rdata(bus_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
      .rst_req(rst_req), .cache_flush(cache_flush)
   );

   // Array model: one-cycle read
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata     <= mem[mem_addr];
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every answered read
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
               check(0, "R2", "unexpected rvalid", 1, 0);
            end else begin
               exp_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (e.chk_data) check(bus_rdata == e.data, t, "rdata", bus_rdata, e.data);
               check(nmi_req == e.nmi, t, "nmi_req", nmi_req, e.nmi);
               check(rst_req == e.rst, t, "rst_req", rst_req, e.rst);
               check(cache_flush == e.flush, t, "cache_flush", cache_flush, e.flush);
            end
         end else if (nmi_req || rst_req || cache_flush) begin
            check(0, "R6", "request pulse without read", {nmi_req, rst_req, cache_flush}, 0);
         end
      end
   end

   task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_be = be; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 0; bus_we = 0;
      if (be != 2'b11) begin
         check(bus_ready == 0, "R3", "ready in merge cycle", bus_ready, 0);
         @(negedge clk);
         check(bus_ready == 1, "R3", "ready after merge", bus_ready, 1);
      end
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input logic [15:0] d, input bit cd,
                           input bit n, input bit r, input bit f, input string req);
      exp_q.push_back({d, cd, n, r, f});
      tag_q.push_back(req);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      bus_req = 0;
      check(bus_rvalid == 0, "R2", "rvalid one cycle after accept", bus_rvalid, 0);
      @(negedge clk);
      check(bus_rvalid == 1, "R2", "rvalid two cycles after accept", bus_rvalid, 1);
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [7:0] d);
      @(negedge clk);
      reg_we = 1; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(reg_rdata == 8'h00, "R11", "reg_rdata", reg_rdata, 0);
      check(bus_ready == 1, "R11", "bus_ready", bus_ready, 1);
      check(bus_rvalid == 0 && nmi_req == 0 && rst_req == 0 && cache_flush == 0,
            "R11", "outputs", {bus_rvalid, nmi_req, rst_req, cache_flush}, 0);
      rst_n = 1;
      @(negedge clk);

      // R1: word writes and clean reads with several patterns
      bus_write(6'd1, 16'hA5C3, 2'b11);
      bus_write(6'd2, 16'hFFFF, 2'b11);
      bus_write(6'd3, 16'h0001, 2'b11);
      bus_write(6'd4, 16'h8000, 2'b11);
      check(mem[1][15:0] == 16'hA5C3, "R1", "stored data bits", mem[1][15:0], 16'hA5C3);
      bus_read(6'd1, 16'hA5C3, 1, 0, 0, 0, "R1");
      bus_read(6'd2, 16'hFFFF, 1, 0, 0, 0, "R1");
      bus_read(6'd3, 16'h0001, 1, 0, 0, 0, "R1");
      bus_read(6'd4, 16'h8000, 1, 0, 0, 0, "R1");
      check(reg_rdata == 8'h00, "R1", "no flag on clean reads", reg_rdata, 0);

      // R3: byte lane writes
      bus_write(6'd5, 16'h1234, 2'b11);
      bus_write(6'd5, 16'hEEAB, 2'b01);
      bus_read(6'd5, 16'h12AB, 1, 0, 0, 0, "R3");
      bus_write(6'd5, 16'h77EE, 2'b10);
      bus_read(6'd5, 16'h77AB, 1, 0, 0, 0, "R3");

      // R10: enable field layout and readback
      reg_write(8'h70);
      check(reg_rdata == 8'h70, "R10", "enables readback", reg_rdata, 8'h70);
      reg_write(8'h8C);
      check(reg_rdata == 8'h00, "R10", "unused bits read 0", reg_rdata, 0);

      // R4: single data-bit error, interrupt enable off
      mem[1][6] = ~mem[1][6];
      bus_read(6'd1, 16'hA5C3, 1, 0, 0, 0, "R4");
      check(reg_rdata == 8'h01, "R4", "ce flag", reg_rdata, 8'h01);

      // R9: write 0 keeps flag, write 1 clears
      reg_write(8'h00);
      check(reg_rdata[0] == 1, "R9", "flag after writing 0", reg_rdata[0], 1);
      reg_write(8'h01);
      check(reg_rdata[0] == 0, "R9", "flag after writing 1", reg_rdata[0], 0);

      // R5: check-bit error only
      mem[2][18] = ~mem[2][18];
      bus_read(6'd2, 16'hFFFF, 1, 0, 0, 0, "R5");
      check(reg_rdata == 8'h01, "R5", "ce flag", reg_rdata, 8'h01);
      reg_write(8'h01);

      // R6: correctable error with interrupt enable on
      reg_write(8'h10);
      mem[3][15] = ~mem[3][15];
      bus_read(6'd3, 16'h0001, 1, 1, 0, 0, "R6");
      check(reg_rdata == 8'h11, "R6", "ce flag and enable", reg_rdata, 8'h11);
      reg_write(8'h01);

      // R7: double error, only flush (no enables)
      mem[4][0] = ~mem[4][0];
      mem[4][9] = ~mem[4][9];
      bus_read(6'd4, 16'h0000, 0, 0, 0, 1, "R7");
      check(reg_rdata == 8'h02, "R7", "ue flag", reg_rdata, 8'h02);
      reg_write(8'h02);

      // R8: interrupt enable only -> nmi
      reg_write(8'h20);
      bus_read(6'd4, 16'h0000, 0, 1, 0, 1, "R8");
      // R8: reset enable only -> reset
      reg_write(8'h42);
      bus_read(6'd4, 16'h0000, 0, 0, 1, 1, "R8");
      // R8: both set -> reset wins, no nmi
      reg_write(8'h62);
      bus_read(6'd4, 16'h0000, 0, 0, 1, 1, "R8");
      check(reg_rdata == 8'h62, "R8", "ue flag with both enables", reg_rdata, 8'h62);
      reg_write(8'h02);

      // R9: error in the same cycle as a clear keeps the flag
      mem[1][6] = ~mem[1][6];
      mem[1][11] = ~mem[1][11];
      exp_q.push_back({16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0});
      tag_q.push_back("R9");
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = 6'd1;
      @(negedge clk);
      bus_req = 0; reg_we = 1; reg_wdata = 8'h01;
      @(negedge clk);
      reg_we = 0;
      check(reg_rdata[0] == 1, "R9", "flag kept on colliding clear", reg_rdata[0], 1);
      reg_write(8'h01);
      check(reg_rdata[0] == 0, "R9", "flag cleared afterwards", reg_rdata[0], 0);

      // R3 with R4: partial write corrects the other lane before re-encoding
      bus_write(6'd6, 16'h3C5A, 2'b11);
      mem[6][12] = ~mem[6][12];
      bus_write(6'd6, 16'h0099, 2'b01);
      check(mem[6][15:0] == 16'h3C99, "R3", "merged stored data", mem[6][15:0], 16'h3C99);
      check(reg_rdata[0] == 1, "R4", "ce flag from merge read", reg_rdata[0], 1);
      reg_write(8'h01);
      bus_read(6'd6, 16'h3C99, 1, 0, 0, 0, "R3");
      check(reg_rdata == 8'h00, "R3", "merged word is clean", reg_rdata, 0);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2", "all reads answered", exp_q.size(), 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule